// File: doc/BRIEF.md
# Trigger-Level Serial Receive Queue

This block is the receive side of a serial port's byte buffer. Bytes handed over by the line sampler are held in a sixteen-entry first-in first-out queue. The processor drains the queue with a read strobe. The block reports how many bytes are waiting. A "receive full" flag rises once the fill reaches a programmable trigger level. An idle "data ready" flag covers a short burst that never reaches that level: it rises after two frame periods pass with no new byte.

Three further functions sit around the queue. A byte that arrives while the queue is full is lost, and that event sets a sticky overrun flag. While the overrun flag is set, reception stops. Software clears status flags by writing zeros, and a clear is refused while the condition behind the flag still holds. The two interrupt lines are the receive line, fed by the receive-full and data-ready flags, and the error line, fed by the overrun flag. Each line is gated by its enables.

Top module: `rx_trig_fifo`

## Requirements
- R1: The queue holds at most 16 bytes. A byte offered while 16 bytes are held and no read happens in that cycle is discarded, and the stored bytes are unchanged.
- R2: A write on `ctrl_wr` loads the trigger level from `ctrl_word[7:6]`, with 0→1, 1→4, 2→8 and 3→14 bytes. After reset the level is 1.
- R3: `rdf` is set when an accepted byte brings the fill count to or above the trigger level. `rx_irq` is high exactly while `rxi_en` is high and `rdf` or `dr` is set.
- R4: An accepted byte that meets a full queue sets `orer`. `err_irq` is high while `orer` is set and either `rxi_en` or `rei_en` is high.
- R5: Bytes are ignored while `rx_en` is low or `orer` is set. A status write with `sts_clr_n[2]`=0 clears `orer`, which also drops `err_irq`.
- R6: On a `frame_tick` cycle, `dr` is set when three conditions hold. The count after that cycle is non-zero and below the trigger. No byte is accepted in that cycle. No byte was accepted in the current tick window or the previous one.
- R7: A read that leaves the count below the trigger clears `rdf`. A read that empties the queue also clears `dr`.
- R8: A status write with `sts_clr_n[1]`=0 clears `rdf` only if the count is below the trigger. A status write with `sts_clr_n[0]`=0 clears `dr` only if the queue is empty. A bit written as 1 has no effect.
- R9: `fifo_clr` empties the queue, zeroes the count and clears `rdf` and `dr`, and so withdraws `rx_irq`. It overrides any byte or read in the same cycle.
- R10: `fill_cnt` shows the number of bytes held, from 0 to 16. Reads and accepted bytes change it by one each, and both in one cycle leave it unchanged.
- R11: A read of an empty queue sets `rd_data` to 0x00 and changes no count or flag.
- R12: Bytes leave in arrival order. `rd_data` shows the byte one cycle after `rd_en` and holds it until the next read.
- R13: After reset the count, all flags, both interrupts and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Byte arrival strobe |
| rx_byte | input | 8 | Arriving byte |
| rx_en | input | 1 | Receive enable |
| frame_tick | input | 1 | One pulse per frame time |
| rd_en | input | 1 | Processor read strobe |
| rd_data | output | 8 | Byte returned by the last read |
| fifo_clr | input | 1 | Queue reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_word | input | 8 | Control word, trigger select in bits 7:6 |
| sts_wr | input | 1 | Status write strobe |
| sts_clr_n | input | 3 | Write-zero clears: bit 0 data ready, bit 1 receive full, bit 2 overrun |
| rxi_en | input | 1 | Receive interrupt enable |
| rei_en | input | 1 | Receive error interrupt enable |
| fill_cnt | output | 5 | Bytes held |
| rdf | output | 1 | Receive full flag |
| dr | output | 1 | Idle data ready flag |
| orer | output | 1 | Overrun flag |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Error interrupt |

## Verification
The assertions check the cycle-local rules on every cycle. These are the count bound, the hold at full with the overrun flag that follows, the frozen count while reception is blocked, the effect of a queue reset, the zero returned by an empty read, and the gating of the receive interrupt. Some behaviour depends on history that no single-cycle property captures, and only the bench's scenarios can show it. That covers the two-tick quiet window before the data-ready flag, clears refused at and above the trigger, the arrival order of bytes through a wrapping queue, and each trigger level. The bench therefore runs a reference model on every cycle of directed and random traffic.

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_en,
  input  logic          frame_tick,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          fifo_clr,
  input  logic          ctrl_wr,
  input  logic [7:0]    ctrl_word,
  input  logic          sts_wr,
  input  logic [2:0]    sts_clr_n,
  input  logic          rxi_en,
  input  logic          rei_en,
  output logic [CW-1:0] fill_cnt,
  output logic          rdf,
  output logic          dr,
  output logic          orer,
  output logic          rx_irq,
  output logic          err_irq
);

  function automatic logic [CW-1:0] level(input logic [1:0] sel);
    case (sel)
      2'd0:    level = CW'(1);
      2'd1:    level = CW'(DEPTH / 4);
      2'd2:    level = CW'(DEPTH / 2);
      default: level = CW'(DEPTH - 2);
    endcase
  endfunction

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    bump = (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] cnt, cnt_n, trig;
  logic          seen_cur, seen_prev;

  wire unused_ctrl = ^ctrl_word[5:0];

  wire accept  = rx_valid & rx_en & ~orer;
  wire rd_ok   = rd_en & (cnt != '0) & ~fifo_clr;
  wire full    = (cnt == CW'(DEPTH));
  wire enq     = accept & ~fifo_clr & (~full | rd_ok);
  wire ovr     = accept & ~fifo_clr & full & ~rd_ok;

  assign cnt_n = cnt + CW'(enq) - CW'(rd_ok);

  wire quiet    = ~accept & ~seen_cur & ~seen_prev;
  wire dr_set   = frame_tick & quiet & ~fifo_clr & (cnt_n != '0) & (cnt_n < trig);
  wire rdf_wclr = sts_wr & ~sts_clr_n[1] & (cnt < trig);
  wire dr_wclr  = sts_wr & ~sts_clr_n[0] & (cnt == '0);

  always_ff @(posedge clk) begin
    if (enq) mem[tail] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else if (fifo_clr) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (rd_ok) head <= bump(head);
      if (enq)   tail <= bump(tail);
      cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_ok ? mem[head] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdf <= 1'b0;
      dr  <= 1'b0;
    end else if (fifo_clr) begin
      rdf <= 1'b0;
      dr  <= 1'b0;
    end else begin
      if (enq && cnt_n >= trig)
        rdf <= 1'b1;
      else if ((rd_ok && cnt_n < trig) || rdf_wclr)
        rdf <= 1'b0;
      if (dr_set)
        dr <= 1'b1;
      else if ((rd_ok && cnt_n == '0) || dr_wclr)
        dr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      orer <= 1'b0;
    else if (ovr)
      orer <= 1'b1;
    else if (sts_wr && !sts_clr_n[2])
      orer <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      trig <= CW'(1);
    else if (ctrl_wr)
      trig <= level(ctrl_word[7:6]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_cur  <= 1'b0;
      seen_prev <= 1'b0;
    end else if (frame_tick) begin
      seen_prev <= seen_cur | accept;
      seen_cur  <= 1'b0;
    end else begin
      seen_cur  <= seen_cur | accept;
    end
  end

  assign fill_cnt = cnt;
  assign rx_irq   = rxi_en & (rdf | dr);
  assign err_irq  = orer & (rxi_en | rei_en);

endmodule

// File: rtl/rx_trig_fifo_chk.sv
module rx_trig_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_en,
  input logic          rd_en,
  input logic          fifo_clr,
  input logic          sts_wr,
  input logic          rxi_en,
  input logic [CW-1:0] fill_cnt,
  input logic [DW-1:0] rd_data,
  input logic          rdf,
  input logic          dr,
  input logic          orer,
  input logic          rx_irq
);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(DEPTH)); // R10

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == CW'(DEPTH)) && rx_valid && !rd_en && !fifo_clr |=> fill_cnt == CW'(DEPTH)); // R1

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == CW'(DEPTH)) && rx_valid && rx_en && !rd_en && !fifo_clr && !sts_wr |=> orer); // R4

  AST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en || orer) && !rd_en && !fifo_clr |=> fill_cnt == $past(fill_cnt)); // R5

  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (fill_cnt == '0) && !rdf && !dr); // R9

  AST_EMPTY_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (fill_cnt == '0) && !rx_valid && !fifo_clr |=> (rd_data == '0) && (fill_cnt == '0)); // R11

  AST_DR_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (fill_cnt == CW'(1)) && !rx_valid && !fifo_clr |=> !dr); // R7

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !rxi_en |-> !rx_irq); // R3

endmodule

bind rx_trig_fifo rx_trig_fifo_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_en(rx_en), .rd_en(rd_en),
  .fifo_clr(fifo_clr), .sts_wr(sts_wr), .rxi_en(rxi_en), .fill_cnt(fill_cnt),
  .rd_data(rd_data), .rdf(rdf), .dr(dr), .orer(orer), .rx_irq(rx_irq)
);

// File: tb/rx_trig_fifo_tb.sv
`timescale 1ns/1ps
module rx_trig_fifo_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxv = 0, rxen = 0, tick = 0, rd = 0, clr = 0, cw = 0, sw = 0, rie = 0, eie = 0;
  logic [7:0] rxb = 0, cword = 0;
  logic [2:0] sclr_n = 3'b111;
  logic [7:0] rd_data;
  logic [4:0] fill_cnt;
  logic       rdf, dr, orer, rx_irq, err_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] mq[$];
  int         mtrig = 1;
  bit         mrdf, mdr, morer, mseen_c, mseen_p;
  logic [7:0] mrd;

  always #10 clk = ~clk;

  rx_trig_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rxv), .rx_byte(rxb), .rx_en(rxen),
    .frame_tick(tick), .rd_en(rd), .rd_data(rd_data), .fifo_clr(clr),
    .ctrl_wr(cw), .ctrl_word(cword), .sts_wr(sw), .sts_clr_n(sclr_n),
    .rxi_en(rie), .rei_en(eie), .fill_cnt(fill_cnt), .rdf(rdf), .dr(dr),
    .orer(orer), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic int lvl(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic mstep();
    int  c = mq.size();
    int  cn;
    bit  acc, rdok, enq, ovr, ds, nrdf, ndr;
    acc  = rxv && rxen && !morer;
    rdok = rd && c != 0 && !clr;
    enq  = acc && !clr && (c < 16 || rdok);
    ovr  = acc && !clr && c == 16 && !rdok;
    cn   = c + int'(enq) - int'(rdok);
    ds   = tick && !acc && !mseen_c && !mseen_p && !clr && cn != 0 && cn < mtrig;
    nrdf = mrdf;
    ndr  = mdr;
    if (clr) begin
      nrdf = 0; ndr = 0;
    end else begin
      if (enq && cn >= mtrig) nrdf = 1;
      else if ((rdok && cn < mtrig) || (sw && !sclr_n[1] && c < mtrig)) nrdf = 0;
      if (ds) ndr = 1;
      else if ((rdok && cn == 0) || (sw && !sclr_n[0] && c == 0)) ndr = 0;
    end
    if (ovr) morer = 1;
    else if (sw && !sclr_n[2]) morer = 0;
    if (rd) mrd = rdok ? mq[0] : 8'h00;
    if (clr) mq.delete();
    else begin
      if (rdok) void'(mq.pop_front());
      if (enq) mq.push_back(rxb);
    end
    if (tick) begin
      mseen_p = mseen_c || acc;
      mseen_c = 0;
    end else mseen_c = mseen_c || acc;
    if (cw) mtrig = lvl(cword[7:6]);
    mrdf = nrdf;
    mdr  = ndr;
  endtask

  task automatic cyc();
    @(posedge clk);
    mstep();
    @(negedge clk);
    chk("R10 fill count", int'(fill_cnt), mq.size());
    chk("R3 rdf flag", int'(rdf), int'(mrdf));
    chk("R6 dr flag", int'(dr), int'(mdr));
    chk("R4 orer flag", int'(orer), int'(morer));
    chk("R7 rx_irq", int'(rx_irq), int'(rie && (mrdf || mdr)));
    chk("R5 err_irq", int'(err_irq), int'(morer && (rie || eie)));
    chk("R12 rd_data", int'(rd_data), int'(mrd));
  endtask

  task automatic quiet_inputs();
    rxv = 0; tick = 0; rd = 0; clr = 0; cw = 0; sw = 0; sclr_n = 3'b111;
  endtask

  task automatic push(input logic [7:0] b);
    rxv = 1; rxb = b; cyc(); quiet_inputs();
  endtask

  task automatic pop();
    rd = 1; cyc(); quiet_inputs();
  endtask

  task automatic ftick();
    tick = 1; cyc(); quiet_inputs();
  endtask

  task automatic setlvl(input logic [1:0] s);
    cw = 1; cword = {s, 6'h15}; cyc(); quiet_inputs();
  endtask

  task automatic swr(input logic [2:0] v);
    sw = 1; sclr_n = v; cyc(); quiet_inputs();
  endtask

  task automatic qclr();
    clr = 1; cyc(); quiet_inputs();
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL R13 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c0d));
    mrd = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R13 reset count", int'(fill_cnt), 0);
    chk("R13 reset rdf", int'(rdf), 0);
    chk("R13 reset dr", int'(dr), 0);
    chk("R13 reset orer", int'(orer), 0);
    chk("R13 reset irqs", int'({rx_irq, err_irq}), 0);
    chk("R13 reset rd_data", int'(rd_data), 0);

    rxen = 1; rie = 1; eie = 0;
    push(8'h11);
    chk("R2 reset trigger one sets rdf", int'(rdf), 1);
    push(8'h22); push(8'h33);
    chk("R10 three bytes", int'(fill_cnt), 3);
    pop(); chk("R12 order first", int'(rd_data), 8'h11);
    pop(); chk("R12 order second", int'(rd_data), 8'h22);
    pop(); chk("R12 order third", int'(rd_data), 8'h33);
    chk("R7 drained rdf", int'(rdf), 0);
    chk("R7 drained irq", int'(rx_irq), 0);
    pop();
    chk("R11 empty read data", int'(rd_data), 0);
    chk("R11 empty read count", int'(fill_cnt), 0);

    setlvl(2'd1);
    push(8'h41); push(8'h42); push(8'h43);
    chk("R2 level four not reached", int'(rdf), 0);
    push(8'h44);
    chk("R3 level four reached", int'(rdf), 1);
    chk("R3 rx_irq raised", int'(rx_irq), 1);
    swr(3'b101);
    chk("R8 rdf clear refused", int'(rdf), 1);
    pop();
    chk("R7 below trigger clears rdf", int'(rdf), 0);

    ftick(); ftick();
    chk("R6 dr waits two quiet ticks", int'(dr), 0);
    ftick();
    chk("R6 dr after quiet ticks", int'(dr), 1);
    chk("R6 rx_irq with dr", int'(rx_irq), 1);
    swr(3'b110);
    chk("R8 dr clear refused with data", int'(dr), 1);
    pop(); pop(); pop();
    chk("R7 empty clears dr", int'(dr), 0);

    for (int i = 0; i < 5; i++) push(8'h60 + 8'(i));
    setlvl(2'd0);
    ftick(); ftick(); ftick();
    qclr();
    chk("R9 clear count", int'(fill_cnt), 0);
    chk("R9 clear flags", int'({rdf, dr, rx_irq}), 0);

    setlvl(2'd3);
    for (int i = 0; i < 13; i++) push(8'h80 + 8'(i));
    chk("R2 level fourteen not reached", int'(rdf), 0);
    for (int i = 13; i < 16; i++) push(8'h80 + 8'(i));
    chk("R1 full count", int'(fill_cnt), 16);
    push(8'hEE);
    chk("R4 overrun flag", int'(orer), 1);
    chk("R4 err_irq", int'(err_irq), 1);
    chk("R1 full drop count", int'(fill_cnt), 16);
    pop();
    chk("R12 head byte kept", int'(rd_data), 8'h80);
    push(8'hEF);
    chk("R5 blocked by overrun", int'(fill_cnt), 15);
    swr(3'b011);
    chk("R5 overrun cleared", int'(orer), 0);
    chk("R5 err_irq dropped", int'(err_irq), 0);
    for (int i = 0; i < 15; i++) pop();
    chk("R1 dropped byte absent", int'(rd_data), 8'h8F);
    chk("R1 drained", int'(fill_cnt), 0);

    rxen = 0;
    push(8'h55);
    chk("R5 rx_en low ignores byte", int'(fill_cnt), 0);
    rxen = 1; rie = 0; eie = 1;
    for (int i = 0; i < 17; i++) push(8'(i));
    chk("R4 error enable alone", int'(err_irq), 1);
    chk("R3 rx_irq gated off", int'(rx_irq), 0);
    qclr(); swr(3'b011);
    rie = 1;

    for (int n = 0; n < 4000; n++) begin
      rxv    = ($urandom % 100) < 45;
      rxb    = 8'($urandom);
      rd     = ($urandom % 100) < 35;
      tick   = ($urandom % 100) < 25;
      sw     = ($urandom % 100) < 8;
      sclr_n = 3'($urandom);
      clr    = ($urandom % 100) < 2;
      cw     = ($urandom % 100) < 4;
      cword  = 8'($urandom);
      rxen   = ($urandom % 100) < 95;
      if (($urandom % 100) < 3) rie = 1'($urandom);
      if (($urandom % 100) < 3) eie = 1'($urandom);
      cyc();
    end
    quiet_inputs();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule